// File: doc/BRIEF.md
# Memory Reference Issue Arbiter

This block picks, once per clock, which memory requester is allowed to issue. Five requester classes compete: CPU scalar references, I/O references, block transfers, exchange sequences and instruction fetch sequences. Scalar and I/O references are short, single references that issue as long as an external bank conflict check clears them. The three sequence classes are long and take memory for themselves. They start only when the memory banks report quiet, and for the length of the sequence they shut out every other requester.

I/O references are treated with two extra rules. First, a rejected I/O reference is held off for a fixed retry interval before the arbiter looks at that request line again. Second, a pending-I/O flag remembers that an I/O reference was turned away. While that flag is set, no new block transfer may start, so a run of block transfers cannot starve I/O. All grants, the lockout status and the I/O holdoff and pending status are registered outputs.

Top module: `mem_issue_arbiter`

## Requirements
- R1: After a synchronous active-high reset, all five grant outputs, `mem_locked`, `io_wait` and `io_pend` are 0.
- R2: At most one of the five grant outputs is 1 in any cycle.
- R3: A scalar request with `scal_conflict` low is granted one cycle after it is sampled, provided `mem_locked` was low when it was sampled. It wins over an I/O request sampled in the same cycle.
- R4: An I/O request with `io_conflict` low is granted one cycle after it is sampled. This holds only when `scal_req`, `mem_locked` and `io_wait` were all low when it was sampled.
- R5: An I/O request sampled with `io_wait` low and not granted is a rejection. Such a request was sampled with `mem_locked`, `scal_req` or `io_conflict` high. After a rejection, `io_wait` is 1 for the next 7 cycles. The I/O request line is ignored at the 7 following decisions. It is considered again at the 8th clock after the rejecting one.
- R6: A sequence is granted only when `banks_quiet` is 1 and no scalar or I/O grant is made at the same decision. Among the sequence classes, instruction fetch beats exchange, and exchange beats block transfer.
- R7: A sequence grant raises `mem_locked` in the same cycle as the grant. `mem_locked` stays 1 for L cycles, where L is that class's length input sampled with the request; a length of 0 counts as 1. No grant of any class appears while a decision is made with `mem_locked` high.
- R8: A rejection sets `io_pend` from the next cycle, and an I/O grant clears it. No block transfer is granted from a decision made while `io_pend` is 1. Instruction fetch and exchange grants are unaffected by `io_pend`.
- R9: Every grant is a one-cycle pulse per decision, registered one clock after the inputs it is based on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scal_req | input | 1 | CPU scalar reference request |
| scal_conflict | input | 1 | Bank conflict found for the scalar reference |
| io_req | input | 1 | I/O reference request |
| io_conflict | input | 1 | Bank conflict found for the I/O reference |
| blk_req | input | 1 | Block transfer request |
| xchg_req | input | 1 | Exchange sequence request |
| fetch_req | input | 1 | Instruction fetch sequence request |
| banks_quiet | input | 1 | All memory banks idle |
| blk_len | input | LEN_W | Block transfer length in cycles |
| xchg_len | input | LEN_W | Exchange sequence length in cycles |
| fetch_len | input | LEN_W | Instruction fetch sequence length in cycles |
| scal_gnt | output | 1 | Scalar reference granted |
| io_gnt | output | 1 | I/O reference granted |
| blk_gnt | output | 1 | Block transfer granted |
| xchg_gnt | output | 1 | Exchange sequence granted |
| fetch_gnt | output | 1 | Instruction fetch sequence granted |
| mem_locked | output | 1 | A sequence owns memory |
| io_wait | output | 1 | I/O retry holdoff running |
| io_pend | output | 1 | A rejected I/O reference is still owed a grant |

## Verification
A lock counter loaded with a wrong length shows up at once as a `mem_locked` window of the wrong width. It also shows up as a scalar grant that arrives one cycle early or late after the window. An off-by-one in the retry countdown moves the first accepted I/O grant by a cycle, and that shift appears eight clocks after the rejection. A pending flag that is stuck or never set shows up as a block transfer granted while an I/O reference is owed, or as a block transfer refused forever after the I/O grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // grant vector positions
  localparam int NSRC   = 5;
  localparam int G_SCAL = 0;
  localparam int G_IO   = 1;
  localparam int G_BLK  = 2;
  localparam int G_XCHG = 3;
  localparam int G_FTCH = 4;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_SCAL = 3'd1,
    SRC_IO   = 3'd2,
    SRC_BLK  = 3'd3,
    SRC_XCHG = 3'd4,
    SRC_FTCH = 3'd5
  } src_e;

  function automatic logic is_seq(input src_e s);
    return (s == SRC_BLK) || (s == SRC_XCHG) || (s == SRC_FTCH);
  endfunction
endpackage

// File: rtl/arb_decide.sv
// Combinational choice of the winning requester for this clock.
module arb_decide
  import arb_pkg::*;
(
  input  logic scal_req,
  input  logic scal_conflict,
  input  logic io_req,
  input  logic io_conflict,
  input  logic blk_req,
  input  logic xchg_req,
  input  logic fetch_req,
  input  logic banks_quiet,
  input  logic locked,
  input  logic io_hold,
  input  logic io_owed,
  output src_e pick,
  output logic io_reject
);
  logic scal_ok, io_live, io_ok, seq_ok;

  always_comb begin
    scal_ok   = scal_req & ~scal_conflict & ~locked;
    io_live   = io_req & ~io_hold;
    io_ok     = io_live & ~locked & ~scal_req & ~io_conflict;
    io_reject = io_live & ~io_ok;
    seq_ok    = ~locked & banks_quiet & ~scal_ok & ~io_ok;

    pick = SRC_NONE;
    if (scal_ok)                          pick = SRC_SCAL;
    else if (io_ok)                       pick = SRC_IO;
    else if (seq_ok && fetch_req)         pick = SRC_FTCH;
    else if (seq_ok && xchg_req)          pick = SRC_XCHG;
    else if (seq_ok && blk_req && !io_owed) pick = SRC_BLK;
  end
endmodule

// File: rtl/seq_lock_timer.sv
// Counts down the exclusive-ownership window of a running sequence.
module seq_lock_timer #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             locked
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] load_val;

  always_comb load_val = (len == '0) ? ONE : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (start) begin
      cnt    <= load_val;
      locked <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - ONE;
      locked <= (cnt > ONE);
    end
  end
endmodule

// File: rtl/io_retry_timer.sv
// Holdoff applied to the I/O request line after a rejection.
module io_retry_timer #(
  parameter int RETRY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic hold
);
  localparam int CW = $clog2(RETRY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(RETRY - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (load) begin
      cnt  <= RELOAD;
      hold <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - ONE;
      hold <= (cnt > ONE);
    end
  end
endmodule

// File: rtl/mem_issue_arbiter.sv
module mem_issue_arbiter
  import arb_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int RETRY = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scal_req,
  input  logic             scal_conflict,
  input  logic             io_req,
  input  logic             io_conflict,
  input  logic             blk_req,
  input  logic             xchg_req,
  input  logic             fetch_req,
  input  logic             banks_quiet,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [LEN_W-1:0] xchg_len,
  input  logic [LEN_W-1:0] fetch_len,
  output logic             scal_gnt,
  output logic             io_gnt,
  output logic             blk_gnt,
  output logic             xchg_gnt,
  output logic             fetch_gnt,
  output logic             mem_locked,
  output logic             io_wait,
  output logic             io_pend
);
  src_e             pick;
  logic             io_reject;
  logic             seq_start;
  logic [LEN_W-1:0] seq_len;
  logic [NSRC-1:0]  gnt_d, gnt_q;

  arb_decide u_decide (
    .scal_req      (scal_req),
    .scal_conflict (scal_conflict),
    .io_req        (io_req),
    .io_conflict   (io_conflict),
    .blk_req       (blk_req),
    .xchg_req      (xchg_req),
    .fetch_req     (fetch_req),
    .banks_quiet   (banks_quiet),
    .locked        (mem_locked),
    .io_hold       (io_wait),
    .io_owed       (io_pend),
    .pick          (pick),
    .io_reject     (io_reject)
  );

  always_comb begin
    seq_start = is_seq(pick);
    case (pick)
      SRC_FTCH: seq_len = fetch_len;
      SRC_XCHG: seq_len = xchg_len;
      default:  seq_len = blk_len;
    endcase
  end

  seq_lock_timer #(.LEN_W(LEN_W)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .start  (seq_start),
    .len    (seq_len),
    .locked (mem_locked)
  );

  io_retry_timer #(.RETRY(RETRY)) u_retry (
    .clk  (clk),
    .rst  (rst),
    .load (io_reject),
    .hold (io_wait)
  );

  // decode the pick into a one-hot grant vector
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_dec
      always_comb gnt_d[gi] = (pick == src_e'(gi + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      io_pend <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      if (gnt_d[G_IO])   io_pend <= 1'b0;
      else if (io_reject) io_pend <= 1'b1;
    end
  end

  always_comb begin
    scal_gnt  = gnt_q[G_SCAL];
    io_gnt    = gnt_q[G_IO];
    blk_gnt   = gnt_q[G_BLK];
    xchg_gnt  = gnt_q[G_XCHG];
    fetch_gnt = gnt_q[G_FTCH];
  end
endmodule

// File: rtl/arb_issue_chk.sv
module arb_issue_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] gnt,
  input logic       scal_req,
  input logic       scal_conflict,
  input logic       banks_quiet,
  input logic       mem_locked,
  input logic       io_wait,
  input logic       io_pend
);
  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  // R3
  scalar_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (scal_req && !scal_conflict && !mem_locked) |=> gnt[0]);
  // R5
  io_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    io_wait |=> !gnt[1]);
  // R6
  seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[2] || gnt[3] || gnt[4]) |-> $past(banks_quiet));
  // R7
  seq_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[2] || gnt[3] || gnt[4]) |-> mem_locked);
  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    mem_locked |=> (gnt == 5'b0));
  // R8
  io_fair_chk: assert property (@(posedge clk) disable iff (rst)
    io_pend |=> !gnt[2]);
endmodule

bind mem_issue_arbiter arb_issue_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .gnt           ({fetch_gnt, xchg_gnt, blk_gnt, io_gnt, scal_gnt}),
  .scal_req      (scal_req),
  .scal_conflict (scal_conflict),
  .banks_quiet   (banks_quiet),
  .mem_locked    (mem_locked),
  .io_wait       (io_wait),
  .io_pend       (io_pend)
);

// File: tb/tb_mem_issue_arbiter.sv
module tb_mem_issue_arbiter;
  localparam int LEN_W = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic scal_req = 0, scal_conflict = 0, io_req = 0, io_conflict = 0;
  logic blk_req = 0, xchg_req = 0, fetch_req = 0, banks_quiet = 0;
  logic [LEN_W-1:0] blk_len = 6'd3, xchg_len = 6'd1, fetch_len = 6'd1;
  logic scal_gnt, io_gnt, blk_gnt, xchg_gnt, fetch_gnt;
  logic mem_locked, io_wait, io_pend;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mem_issue_arbiter #(.LEN_W(LEN_W), .RETRY(8)) dut (.*);

  // {sreq,sconf,ireq,iconf,blk,xchg,fetch,quiet, exp s,i,b,x,f}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    13'b1000_0000_10000,  // R3 scalar alone
    13'b1010_0000_10000,  // R3 scalar beats io
    13'b1110_0000_00000,  // R4 io blocked by scalar request
    13'b0010_0000_01000,  // R4 io alone
    13'b0011_0000_00000,  // R5 io conflict rejects
    13'b0000_1111_00001,  // R6 fetch first
    13'b0000_1101_00010,  // R6 exchange over block
    13'b0000_1001_00100,  // R6 block alone
    13'b0000_1000_00000,  // R6 banks busy
    13'b0010_0011_01000,  // R6 io before sequence
    13'b1100_1001_00100   // R6 conflicted scalar lets block go
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    {scal_req, scal_conflict, io_req, io_conflict} = '0;
    {blk_req, xchg_req, fetch_req, banks_quiet} = '0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    cyc();
    rst = 1'b0;
  endtask

  function automatic logic [4:0] gv();
    return {scal_gnt, io_gnt, blk_gnt, xchg_gnt, fetch_gnt};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 grants", 32'(gv()), 0);
    chk("R1 status", {29'd0, mem_locked, io_wait, io_pend}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      {scal_req, scal_conflict, io_req, io_conflict,
       blk_req, xchg_req, fetch_req, banks_quiet} = VEC[v][12:5];
      cyc();
      chk($sformatf("R9 vector %0d", v), 32'(gv()), 32'(VEC[v][4:0]));
      idle();
      cyc();
      chk($sformatf("R9 pulse %0d", v), 32'(gv() & 5'b11000), 0);
    end

    // R7 block length 3 lockout
    do_reset();
    blk_len = 6'd3;
    blk_req = 1; banks_quiet = 1;
    cyc();
    chk("R7 blk grant", blk_gnt, 1);
    chk("R7 locked c1", mem_locked, 1);
    idle(); scal_req = 1;
    cyc();
    chk("R7 scalar held c2", scal_gnt, 0);
    chk("R7 locked c2", mem_locked, 1);
    cyc();
    chk("R7 scalar held c3", scal_gnt, 0);
    chk("R7 locked c3", mem_locked, 1);
    cyc();
    chk("R7 scalar held c4", scal_gnt, 0);
    chk("R7 unlocked c4", mem_locked, 0);
    cyc();
    chk("R7 scalar after lock", scal_gnt, 1);

    // R7 zero length counts as one
    do_reset();
    xchg_len = 6'd0;
    xchg_req = 1; banks_quiet = 1;
    cyc();
    chk("R7 len0 grant", xchg_gnt, 1);
    chk("R7 len0 locked", mem_locked, 1);
    idle(); scal_req = 1;
    cyc();
    chk("R7 len0 held", scal_gnt, 0);
    chk("R7 len0 unlocked", mem_locked, 0);
    cyc();
    chk("R7 len0 scalar", scal_gnt, 1);
    xchg_len = 6'd1;

    // R5 retry interval
    do_reset();
    io_req = 1; io_conflict = 1;
    cyc();
    chk("R5 rejected", io_gnt, 0);
    chk("R5 wait set", io_wait, 1);
    chk("R8 pend set", io_pend, 1);
    io_conflict = 0;
    for (int k = 2; k <= 7; k++) begin
      cyc();
      chk($sformatf("R5 ignored c%0d", k), io_gnt, 0);
      chk($sformatf("R5 wait c%0d", k), io_wait, 1);
    end
    cyc();
    chk("R5 ignored c8", io_gnt, 0);
    chk("R5 wait ends c8", io_wait, 0);
    cyc();
    chk("R5 regrant c9", io_gnt, 1);
    chk("R8 pend cleared", io_pend, 0);

    // R8 block transfer held while io owed
    do_reset();
    io_req = 1; io_conflict = 1;
    cyc();
    idle(); blk_req = 1; banks_quiet = 1;
    cyc();
    chk("R8 blk blocked", blk_gnt, 0);
    xchg_req = 1;
    cyc();
    chk("R8 xchg unaffected", xchg_gnt, 1);
    xchg_req = 0;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk("R8 blk still blocked", blk_gnt, 0);
    end
    blk_req = 0; io_req = 1;
    cyc();
    chk("R8 io served", io_gnt, 1);
    chk("R8 pend low", io_pend, 0);
    io_req = 0; blk_req = 1;
    cyc();
    chk("R8 blk after io", blk_gnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule